// File: doc/BRIEF.md
# Three-Stage Pipelined Logic-Arithmetic Datapath

This block evaluates the expression f = ((a OR b) + c) × (d AND e) on five unsigned 8-bit operands and returns a 16-bit result. The work is split across three register stages so that each stage carries a single operation. Because OR, AND, add and multiply are treated as equal in cost, the two independent bitwise operations share the first stage.

A fresh operand set may be presented on every clock cycle. Its result appears on `f` exactly three rising edges later, and once the pipe is full one result emerges per cycle. There is no handshake and no stall. The surrounding logic supplies operands in a fixed cadence and picks up results with a matching three-cycle offset.

The reset is active-low and asynchronous on assertion. The chip's reset tree is expected to release it synchronously to `clk`. Reset clears every pipeline register, so `f` stays at zero until the first real result arrives.

Top module: `ldp_pipe`

## Requirements
- R1: While `rst_n` is low, and for the first three rising edges after it is released, `f` reads 0, whatever the operands are.
- R2: An operand set sampled at a rising edge appears as f = ((a|b)+c)×(d&e), with all values taken as unsigned, on `f` after the third rising edge that follows. The first of those three edges is the one that samples the set.
- R3: Operand sets applied on consecutive cycles each produce their own result on consecutive cycles, with no gaps and no mixing between sets.
- R4: The carry out of (a|b)+c is kept as a ninth bit. For example, a=0xFF, b=0x00, c=0xFF, d=e=0xFF gives 510×255 mod 65536 = 0xFC02.
- R5: When d&e is 0, `f` is 0 for that operand set, whatever a, b and c are. The AND term reaches the multiply stage unchanged.
- R6: A product above 16 bits is truncated to its low 16 bits. For example, (0xF0|0x00)+0xF0 = 480 and 480×0xC3 = 93600 gives 0x6DA0.
- R7: Asserting `rst_n` in the middle of a stream forces `f` to 0 at once. No result from an operand set sampled before the reset ever appears afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release expected |
| a | input | 8 | Operand ORed with b |
| b | input | 8 | Operand ORed with a |
| c | input | 8 | Addend for the OR term |
| d | input | 8 | Operand ANDed with e |
| e | input | 8 | Operand ANDed with d |
| f | output | 16 | Registered result, low 16 bits of the product |

## Verification
The bound checker checks several things on every cycle: `f` stays at zero during the three-edge fill after reset, and every later `f` equals the expression of the operands seen three edges earlier. It also checks each stage boundary: the 9-bit sum including its carry, the forwarding of the AND term, and the truncated product. A zero AND term forcing a zero result is checked per cycle as well. Only the bench's scenarios can show certain behaviours. These are a reset asserted in mid-stream that discards results already in flight, a near-exhaustive sweep of operand patterns, and the specific carry and truncation corner values, observed together with the back-to-back ordering of results.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  // Default operand and result widths for the datapath.
  localparam int unsigned OPW_DEF  = 8;
  localparam int unsigned RESW_DEF = 16;
  // Number of register stages between an operand set and its result.
  localparam int unsigned STAGES   = 3;
endpackage

// File: rtl/ldp_front.sv
// Stage 1: bitwise OR and AND, with the addend carried alongside.
module ldp_front #(
  parameter int unsigned OPW = ldp_pkg::OPW_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic [OPW-1:0] c,
  input  logic [OPW-1:0] d,
  input  logic [OPW-1:0] e,
  output logic [OPW-1:0] or_q,
  output logic [OPW-1:0] c_q,
  output logic [OPW-1:0] and_q
);

  logic [OPW-1:0] or_nx;
  logic [OPW-1:0] and_nx;
  logic [OPW-1:0] c_nx;

  // Per-bit logic slices.
  for (genvar i = 0; i < OPW; i++) begin : g_bit
    always_comb begin
      or_nx[i]  = a[i] | b[i];
      and_nx[i] = d[i] & e[i];
    end
  end

  always_comb begin
    c_nx = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      or_q  <= '0;
      c_q   <= '0;
      and_q <= '0;
    end else begin
      or_q  <= or_nx;
      c_q   <= c_nx;
      and_q <= and_nx;
    end
  end

endmodule

// File: rtl/ldp_adder.sv
// Stage 2: widened sum, AND term forwarded untouched.
module ldp_adder #(
  parameter int unsigned OPW = ldp_pkg::OPW_DEF,
  localparam int unsigned SW = OPW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] or_i,
  input  logic [OPW-1:0] c_i,
  input  logic [OPW-1:0] and_i,
  output logic [SW-1:0]  sum_q,
  output logic [OPW-1:0] and_q
);

  logic [SW-1:0]  sum_nx;
  logic [OPW-1:0] and_nx;

  always_comb begin
    sum_nx = SW'(or_i) + SW'(c_i);
    and_nx = and_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      and_q <= '0;
    end else begin
      sum_q <= sum_nx;
      and_q <= and_nx;
    end
  end

endmodule

// File: rtl/ldp_mult.sv
// Stage 3: full product, fitted to the result width.
module ldp_mult #(
  parameter int unsigned OPW  = ldp_pkg::OPW_DEF,
  parameter int unsigned RESW = ldp_pkg::RESW_DEF,
  localparam int unsigned SW  = OPW + 1,
  localparam int unsigned PW  = SW + OPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   sum_i,
  input  logic [OPW-1:0]  and_i,
  output logic [RESW-1:0] prod_q
);

  logic [PW-1:0]   prod_full;
  logic [RESW-1:0] prod_nx;

  always_comb begin
    prod_full = PW'(sum_i) * PW'(and_i);
  end

  // The result width picks truncation or zero extension.
  if (RESW <= PW) begin : g_trunc
    always_comb begin
      prod_nx = prod_full[RESW-1:0];
    end
  end else begin : g_extend
    always_comb begin
      prod_nx = RESW'(prod_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else begin
      prod_q <= prod_nx;
    end
  end

endmodule

// File: rtl/ldp_pipe.sv
// Top: three-stage ((a|b)+c)*(d&e) pipeline.
module ldp_pipe #(
  parameter int unsigned OPW  = ldp_pkg::OPW_DEF,
  parameter int unsigned RESW = ldp_pkg::RESW_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  input  logic [OPW-1:0]  c,
  input  logic [OPW-1:0]  d,
  input  logic [OPW-1:0]  e,
  output logic [RESW-1:0] f
);

  localparam int unsigned SW = OPW + 1;

  logic [OPW-1:0] s1_or;
  logic [OPW-1:0] s1_c;
  logic [OPW-1:0] s1_and;
  logic [SW-1:0]  s2_sum;
  logic [OPW-1:0] s2_and;

  ldp_front #(.OPW(OPW)) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .c     (c),
    .d     (d),
    .e     (e),
    .or_q  (s1_or),
    .c_q   (s1_c),
    .and_q (s1_and)
  );

  ldp_adder #(.OPW(OPW)) u_adder (
    .clk   (clk),
    .rst_n (rst_n),
    .or_i  (s1_or),
    .c_i   (s1_c),
    .and_i (s1_and),
    .sum_q (s2_sum),
    .and_q (s2_and)
  );

  ldp_mult #(.OPW(OPW), .RESW(RESW)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .sum_i  (s2_sum),
    .and_i  (s2_and),
    .prod_q (f)
  );

endmodule

// File: rtl/ldp_pipe_chk.sv
// Checker bound to ldp_pipe.
module ldp_pipe_chk #(
  parameter int unsigned OPW  = ldp_pkg::OPW_DEF,
  parameter int unsigned RESW = ldp_pkg::RESW_DEF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OPW-1:0]  a,
  input logic [OPW-1:0]  b,
  input logic [OPW-1:0]  c,
  input logic [OPW-1:0]  d,
  input logic [OPW-1:0]  e,
  input logic [RESW-1:0] f,
  input logic [OPW-1:0]  s1_or,
  input logic [OPW-1:0]  s1_c,
  input logic [OPW-1:0]  s1_and,
  input logic [OPW:0]    s2_sum,
  input logic [OPW-1:0]  s2_and
);

  localparam int unsigned PW = 2 * OPW + 1;

  function automatic logic [RESW-1:0] mul_fit(input logic [OPW:0] s, input logic [OPW-1:0] m);
    logic [PW-1:0] t;
    t = PW'(s) * PW'(m);
    return RESW'(t);
  endfunction

  function automatic logic [RESW-1:0] ref_f(input logic [OPW-1:0] xa, input logic [OPW-1:0] xb,
                                            input logic [OPW-1:0] xc, input logic [OPW-1:0] xd,
                                            input logic [OPW-1:0] xe);
    logic [OPW:0] s;
    s = (OPW+1)'(xa | xb) + (OPW+1)'(xc);
    return mul_fit(s, xd & xe);
  endfunction

  // Edges seen since reset release, saturating at three.
  logic [1:0] fill_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (fill_cnt != 2'd3) begin
      fill_cnt <= fill_cnt + 2'd1;
    end
  end

  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != 2'd3) |-> (f == '0)); // R1

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == 2'd3) |-> (f == ref_f($past(a, 3), $past(b, 3), $past(c, 3), $past(d, 3), $past(e, 3)))); // R2

  AST_SUM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != 2'd0) |-> (s2_sum == ({1'b0, $past(s1_or)} + {1'b0, $past(s1_c)}))); // R4

  AST_AND_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != 2'd0) |-> (s2_and == $past(s1_and))); // R5

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_cnt == 2'd3) && (($past(d, 3) & $past(e, 3)) == '0)) |-> (f == '0)); // R5

  AST_PRODUCT_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != 2'd0) |-> (f == mul_fit($past(s2_sum), $past(s2_and)))); // R6

endmodule

bind ldp_pipe ldp_pipe_chk #(.OPW(OPW), .RESW(RESW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a      (a),
  .b      (b),
  .c      (c),
  .d      (d),
  .e      (e),
  .f      (f),
  .s1_or  (s1_or),
  .s1_c   (s1_c),
  .s1_and (s1_and),
  .s2_sum (s2_sum),
  .s2_and (s2_and)
);

// File: tb/ldp_pipe_test.sv
module ldp_pipe_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  a, b, c, d, e;
  logic [15:0] f;

  int n_tests;
  int n_fail;
  bit done;

  logic [15:0] hist [3];
  string       hist_tag [3];
  logic [31:0] lfsr;

  ldp_pipe uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d), .e(e), .f(f)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] model(input logic [7:0] xa, input logic [7:0] xb,
                                        input logic [7:0] xc, input logic [7:0] xd,
                                        input logic [7:0] xe);
    int unsigned s;
    int unsigned p;
    s = int'(xa | xb) + int'(xc);
    p = s * int'(xd & xe);
    return p[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: f=%h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Check the result due now, then apply a new operand set and release reset.
  task automatic step(input logic [7:0] ia, input logic [7:0] ib, input logic [7:0] ic,
                      input logic [7:0] id, input logic [7:0] ie, input string tag);
    @(negedge clk);
    check(hist_tag[2], f, hist[2]);
    hist[2] = hist[1];  hist_tag[2] = hist_tag[1];
    hist[1] = hist[0];  hist_tag[1] = hist_tag[0];
    hist[0] = model(ia, ib, ic, id, ie);
    hist_tag[0] = tag;
    a = ia; b = ib; c = ic; d = id; e = ie;
    rst_n = 1'b1;
  endtask

  task automatic clear_hist(input string tag);
    for (int k = 0; k < 3; k++) begin
      hist[k] = '0;
      hist_tag[k] = tag;
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    a = 8'h11; b = 8'h22; c = 8'h33; d = 8'hFF; e = 8'hFF;
    clear_hist("R1");
    lfsr = 32'h1ACE_B00C;

    // R1: reset state, operands nonzero during reset
    #20;
    check("R1", f, 16'h0000);

    // R1: the fill cycles after release read zero
    step(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, "R4");
    step(8'hF0, 8'h00, 8'hF0, 8'hC3, 8'hC3, "R6");
    step(8'h7E, 8'h81, 8'h01, 8'hAA, 8'h55, "R5");
    // Explicit corner values from the requirements
    if (model(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF) != 16'hFC02) begin
      n_fail++; $display("FAIL R4: model %h expected fc02", model(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF));
    end
    n_tests++;
    if (model(8'hF0, 8'h00, 8'hF0, 8'hC3, 8'hC3) != 16'h6DA0) begin
      n_fail++; $display("FAIL R6: model %h expected 6da0", model(8'hF0, 8'h00, 8'hF0, 8'hC3, 8'hC3));
    end
    n_tests++;
    step(8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, "R5");
    step(8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, "R5");
    step(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6");
    step(8'h80, 8'h00, 8'h80, 8'h01, 8'h01, "R4");

    // R2: near-exhaustive sweep, every a/b pair with derived c, d, e
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      v = 16'(i);
      step(v[7:0], v[15:8], v[7:0] ^ v[15:8], ~v[15:8], v[7:0] | 8'h81, "R2");
    end

    // R3: back-to-back pseudo-random operand sets
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[7:0], lfsr[15:8], lfsr[23:16], lfsr[31:24], lfsr[11:4], "R3");
    end

    // R7: reset in mid-stream with results in flight
    step(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, "R7");
    step(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, "R7");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", f, 16'h0000);
    clear_hist("R7");
    @(negedge clk);
    check("R7", f, 16'h0000);
    step(8'hC3, 8'h3C, 8'h99, 8'hF7, 8'h7F, "R3");
    step(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, "R3");
    step(8'hA5, 8'h5A, 8'hFF, 8'hEE, 8'hDD, "R3");
    step(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3");
    step(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3");
    step(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3: watchdog expired, got no completion expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule